// File: doc/BRIEF.md
# Dual-Lane Wide-Word Execute Unit

This block accepts one 66-bit instruction bundle per clock and executes two 32-bit operations side by side, one per lane. A 2-bit format selector at the top of the bundle applies to both lanes at once. It chooses between register-register arithmetic, register-immediate arithmetic, jump-target output and an idle cycle. Each lane has its own 6-bit operation code, so the two lanes may run the same operation or different ones on their own operands.

The lanes share a 32-entry register file whose entry zero always reads as zero. Each lane has two read ports and one write port. Results are registered: the data and jump outputs, and any register write, take effect on the clock edge at which the bundle is sampled. They are visible from the following cycle. Register contents are loaded through the normal instruction path, for example with a register-immediate ADD from register zero.

Top module: `vliw_exec_unit`

## Requirements
- R1: The bundle carries the format selector in bits 65:64, the lane 1 instruction in bits 63:32 and the lane 0 instruction in bits 31:0. Within each lane instruction, bits 31:26 are the operation code.
- R2: Selector 01 (register-register) computes rs op rt, with rs = bits 25:21 and rt = bits 20:16. It writes the result to rd = bits 15:11 and shows it on that lane's data output after the sampling edge.
- R3: Selector 10 (register-immediate) computes rs op imm, where imm is bits 15:0 zero-extended. It writes the result to register rt (bits 20:16) and shows it on that lane's data output.
- R4: Operation codes are ADD = 0, SUB = 1 (first operand minus second), AND = 2, OR = 3, NAND = 4 and XOR = 5, with wrap-around arithmetic.
- R5: Any other operation code in selector 01 or 10 drives that lane's data output to zero and writes no register.
- R6: Selector 11 sets each lane's jump output to bits 25:0 of its instruction, zero-extended. The data outputs and the registers stay unchanged.
- R7: Selector 00 leaves all four outputs and all registers unchanged.
- R8: Register 0 always reads as zero. A write to it is discarded, although the computed value still appears on the data output.
- R9: If both lanes write the same register in one bundle, the register keeps lane 1's value.
- R10: Both lanes read register values from before the current bundle's own writes.
- R11: A synchronous reset clears all four outputs and every register.
- R12: The jump outputs keep their value in every selector other than 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bundle | input | 66 | Format selector and two lane instructions |
| dataOut0 | output | 32 | Registered result of lane 0 |
| dataOut1 | output | 32 | Registered result of lane 1 |
| jumpOut0 | output | 32 | Registered jump target of lane 0 |
| jumpOut1 | output | 32 | Registered jump target of lane 1 |

## Verification
The bench builds the unit with its default 32-bit data width and 32 registers. With these values, every 5-bit register field reaches a real entry, including register 0 and the top entry 31. Random bundles draw operation codes from 0 to 7, so the two undefined codes occur often. Register fields are drawn at random across all 32 entries, so same-register writes from both lanes and reads of a register that the same bundle writes occur naturally. Directed cases add to this: a deliberate write conflict, a write to register 0 and a reset in the middle of a run.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
  localparam int INSTR_W = 32;
  localparam int FIELD_W = 26;
  localparam int OPC_W   = 6;
  localparam int LANES   = 2;

  typedef enum logic [1:0] {
    FMT_IDLE = 2'b00,
    FMT_REG  = 2'b01,
    FMT_IMM  = 2'b10,
    FMT_JMP  = 2'b11
  } fmtSel_e;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_OR   = 3'd3,
    ALU_NAND = 3'd4,
    ALU_XOR  = 3'd5
  } aluOp_e;

  typedef struct packed {
    logic   loadData;
    logic   loadJump;
    logic   wrEn;
    logic   useImm;
    logic   zeroRes;
    aluOp_e op;
  } laneCtrl_t;
endpackage

// File: rtl/vliw_ctrl.sv
module vliw_ctrl
  import vliw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            fmt,
  input  logic [LANES*OPC_W-1:0] opcodes,
  output laneCtrl_t [LANES-1:0] ctrl
);
  fmtSel_e fmtSel;
  assign fmtSel = fmtSel_e'(fmt);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [OPC_W-1:0] opc;
    logic             known;
    logic             arith;
    assign opc   = opcodes[l*OPC_W +: OPC_W];
    assign known = (opc <= OPC_W'(5));
    assign arith = (fmtSel == FMT_REG) || (fmtSel == FMT_IMM);

    always_comb begin
      ctrl[l]          = '0;
      ctrl[l].op       = known ? aluOp_e'(opc[2:0]) : ALU_ADD;
      ctrl[l].useImm   = (fmtSel == FMT_IMM);
      ctrl[l].loadData = arith;
      ctrl[l].wrEn     = arith && known;
      ctrl[l].zeroRes  = arith && !known;
      ctrl[l].loadJump = (fmtSel == FMT_JMP);
    end

    // R6: a lane never updates both its data and jump outputs in one bundle
    p_one_target_r6: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ctrl[l].loadData, ctrl[l].loadJump}));
    // R5: undefined operation codes never reach the register file
    p_bad_op_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
      (arith && opc > OPC_W'(5)) |-> (!ctrl[l].wrEn && ctrl[l].zeroRes));
    // R7: the idle selector drives no strobe
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      (fmtSel == FMT_IDLE) |-> !(ctrl[l].loadData || ctrl[l].loadJump || ctrl[l].wrEn));
  end
endmodule

// File: rtl/vliw_datapath.sv
module vliw_datapath
  import vliw_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  laneCtrl_t [LANES-1:0]         ctrl,
  input  logic [LANES-1:0][FIELD_W-1:0] fields,
  output logic [LANES-1:0][DATA_W-1:0]  dataOut,
  output logic [LANES-1:0][DATA_W-1:0]  jumpOut
);
  localparam int ADDR_W = $clog2(REG_CNT);

  logic [DATA_W-1:0] regs [REG_CNT];

  logic [LANES-1:0][DATA_W-1:0] result;
  logic [LANES-1:0][ADDR_W-1:0] dest;

  for (genvar l = 0; l < LANES; l++) begin : g_alu
    logic [ADDR_W-1:0] rsIdx, rtIdx, rdIdx;
    logic [DATA_W-1:0] opA, opB, imm;
    assign rsIdx = fields[l][21 +: ADDR_W];
    assign rtIdx = fields[l][16 +: ADDR_W];
    assign rdIdx = fields[l][11 +: ADDR_W];
    assign imm   = {{(DATA_W-16){1'b0}}, fields[l][15:0]};
    assign opA   = regs[rsIdx];
    assign opB   = ctrl[l].useImm ? imm : regs[rtIdx];
    assign dest[l] = ctrl[l].useImm ? rtIdx : rdIdx;

    always_comb begin
      if (ctrl[l].zeroRes) result[l] = '0;
      else begin
        unique case (ctrl[l].op)
          ALU_ADD:  result[l] = opA + opB;
          ALU_SUB:  result[l] = opA - opB;
          ALU_AND:  result[l] = opA & opB;
          ALU_OR:   result[l] = opA | opB;
          ALU_NAND: result[l] = ~(opA & opB);
          ALU_XOR:  result[l] = opA ^ opB;
          default:  result[l] = '0;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        dataOut[l] <= '0;
        jumpOut[l] <= '0;
      end else begin
        if (ctrl[l].loadData) dataOut[l] <= result[l];
        if (ctrl[l].loadJump) jumpOut[l] <= {{(DATA_W-FIELD_W){1'b0}}, fields[l]};
      end
    end

    // R7: without a data strobe the lane's data output holds
    p_data_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !ctrl[l].loadData |=> $stable(dataOut[l]));
    // R12: without a jump strobe the lane's jump output holds
    p_jump_hold_r12: assert property (@(posedge clk) disable iff (rst)
      !ctrl[l].loadJump |=> $stable(jumpOut[l]));
    // R6: jump targets are zero-extended
    p_jump_zext_r6: assert property (@(posedge clk) disable iff (rst)
      jumpOut[l][DATA_W-1:FIELD_W] == '0);
    // R11: outputs are clear in the cycle after reset
    p_reset_clear_r11: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (dataOut[l] == '0 && jumpOut[l] == '0));
  end

  // Lanes are written in ascending order so the higher lane wins a conflict (R9)
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_CNT; i++) regs[i] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        if (ctrl[l].wrEn && dest[l] != '0) regs[dest[l]] <= result[l];
    end
  end

  // R8: register 0 stays zero
  p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
    regs[0] == '0);
endmodule

// File: rtl/vliw_exec_unit.sv
module vliw_exec_unit
  import vliw_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [LANES*INSTR_W+1:0]       bundle,
  output logic [DATA_W-1:0]              dataOut0,
  output logic [DATA_W-1:0]              dataOut1,
  output logic [DATA_W-1:0]              jumpOut0,
  output logic [DATA_W-1:0]              jumpOut1
);
  laneCtrl_t [LANES-1:0]          ctrl;
  logic [LANES*OPC_W-1:0]         opcodes;
  logic [LANES-1:0][FIELD_W-1:0]  fields;
  logic [LANES-1:0][DATA_W-1:0]   dataOut, jumpOut;

  for (genvar l = 0; l < LANES; l++) begin : g_split
    assign opcodes[l*OPC_W +: OPC_W] = bundle[l*INSTR_W + FIELD_W +: OPC_W];
    assign fields[l]                 = bundle[l*INSTR_W +: FIELD_W];
  end

  vliw_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .fmt     (bundle[LANES*INSTR_W +: 2]),
    .opcodes (opcodes),
    .ctrl    (ctrl)
  );

  vliw_datapath #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .fields  (fields),
    .dataOut (dataOut),
    .jumpOut (jumpOut)
  );

  assign dataOut0 = dataOut[0];
  assign dataOut1 = dataOut[1];
  assign jumpOut0 = jumpOut[0];
  assign jumpOut1 = jumpOut[1];
endmodule

// File: tb/sim_vliw_exec_unit.sv
module sim_vliw_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [65:0] bundle = '0;
  logic [31:0] dataOut0, dataOut1, jumpOut0, jumpOut1;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [31:0] mreg [32];
  logic [31:0] expData [2];
  logic [31:0] expJump [2];

  always #4 clk = ~clk;

  vliw_exec_unit u0 (
    .clk(clk), .rst(rst), .bundle(bundle),
    .dataOut0(dataOut0), .dataOut1(dataOut1),
    .jumpOut0(jumpOut0), .jumpOut1(jumpOut1)
  );

  function automatic logic [31:0] rIns(input logic [5:0] op, input int rs, input int rt, input int rd);
    return {op, 5'(rs), 5'(rt), 5'(rd), 11'd0};
  endfunction

  function automatic logic [31:0] iIns(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  // returns {valid, result}
  function automatic logic [32:0] aluRef(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      6'd0: return {1'b1, a + b};
      6'd1: return {1'b1, a - b};
      6'd2: return {1'b1, a & b};
      6'd3: return {1'b1, a | b};
      6'd4: return {1'b1, ~(a & b)};
      6'd5: return {1'b1, a ^ b};
      default: return {1'b0, 32'd0};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [65:0] b, input string tag);
    logic [31:0] old [32];
    logic        we  [2];
    logic [4:0]  wa  [2];
    logic [31:0] wv  [2];
    @(negedge clk);
    bundle = b;
    @(posedge clk);
    #2;
    for (int i = 0; i < 32; i++) old[i] = mreg[i];
    for (int l = 0; l < 2; l++) begin
      logic [31:0] ins;
      logic [32:0] r;
      ins = b[l*32 +: 32];
      we[l] = 1'b0; wa[l] = '0; wv[l] = '0;
      if (b[65:64] == 2'b01 || b[65:64] == 2'b10) begin
        logic [31:0] opB;
        opB = (b[65:64] == 2'b10) ? {16'd0, ins[15:0]} : old[ins[20:16]];
        r = aluRef(ins[31:26], old[ins[25:21]], opB);
        expData[l] = r[31:0];
        we[l] = r[32];
        wa[l] = (b[65:64] == 2'b10) ? ins[20:16] : ins[15:11];
        wv[l] = r[31:0];
      end else if (b[65:64] == 2'b11) begin
        expJump[l] = {6'd0, ins[25:0]};
      end
    end
    for (int l = 0; l < 2; l++)
      if (we[l] && wa[l] != 0) mreg[wa[l]] = wv[l];
    chk({tag, " data0"}, dataOut0, expData[0]);
    chk({tag, " data1"}, dataOut1, expData[1]);
    chk({tag, " jump0"}, jumpOut0, expJump[0]);
    chk({tag, " jump1"}, jumpOut1, expJump[1]);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    rst = 1'b0;
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    for (int l = 0; l < 2; l++) begin expData[l] = '0; expJump[l] = '0; end
    chk("R11 reset data0", dataOut0, 32'd0);
    chk("R11 reset data1", dataOut1, 32'd0);
    chk("R11 reset jump0", jumpOut0, 32'd0);
    chk("R11 reset jump1", jumpOut1, 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    for (int l = 0; l < 2; l++) begin expData[l] = '0; expJump[l] = '0; end
    repeat (2) @(posedge clk);
    doReset();

    // R11: registers read back as zero after reset (register 31 and 1 through lanes)
    step({2'b01, rIns(6'd0, 31, 0, 0), rIns(6'd0, 1, 0, 0)}, "R11 regs clear");

    // R3 R1: load registers through immediate ADD from r0
    step({2'b10, iIns(6'd0, 0, 7, 16'd8), iIns(6'd0, 0, 5, 16'd9)}, "R3 load a");
    step({2'b10, iIns(6'd0, 0, 3, 16'd10), iIns(6'd0, 0, 6, 16'd4)}, "R3 load b");
    // R2: two register-register adds in one bundle: 10+4 and 8+9
    step({2'b01, rIns(6'd0, 3, 6, 10), rIns(6'd0, 7, 5, 11)}, "R2 dual add");
    chk("R2 lane0 sum", dataOut0, 32'd17);
    chk("R2 lane1 sum", dataOut1, 32'd14);
    // R4: NAND with immediate on lane 0, ADD on lane 1, mixed per lane
    step({2'b10, iIns(6'd0, 7, 12, 16'd660), iIns(6'd4, 6, 13, 16'd2084)}, "R4 nand/add imm");
    chk("R4 nand value", dataOut0, ~(32'd4 & 32'd2084));
    chk("R4 add value", dataOut1, 32'd668);
    // R4: SUB wraps below zero
    step({2'b01, rIns(6'd1, 6, 7, 14), rIns(6'd1, 0, 3, 15)}, "R4 sub wrap");
    chk("R4 sub wrap", dataOut0, 32'hFFFF_FFF6);
    // R9: both lanes write r20, lane 1 wins
    step({2'b10, iIns(6'd0, 0, 20, 16'd9), iIns(6'd0, 0, 20, 16'd5)}, "R9 conflict");
    step({2'b01, rIns(6'd0, 0, 0, 0), rIns(6'd0, 20, 0, 0)}, "R9 readback");
    chk("R9 lane1 wins", dataOut0, 32'd9);
    // R10: lane 0 writes r3 while lane 1 reads r3 in the same bundle
    step({2'b01, rIns(6'd0, 3, 0, 0), rIns(6'd3, 0, 20, 3)}, "R10 same bundle");
    chk("R10 old value", dataOut1, 32'd10);
    // R8: write to r0 shows the value but r0 stays zero
    step({2'b10, iIns(6'd0, 0, 0, 16'd55), iIns(6'd0, 0, 0, 16'd77)}, "R8 r0 write");
    step({2'b01, rIns(6'd2, 0, 0, 0), rIns(6'd4, 0, 0, 0)}, "R8 r0 read");
    chk("R8 nand of zeros", dataOut0, 32'hFFFF_FFFF);
    // R5: unknown opcode zeroes data, no write to r9
    step({2'b10, iIns(6'd7, 0, 9, 16'd123), iIns(6'd6, 7, 9, 16'd99)}, "R5 unknown op");
    chk("R5 zero data", dataOut0, 32'd0);
    step({2'b01, rIns(6'd0, 9, 0, 0), rIns(6'd0, 9, 0, 0)}, "R5 no write");
    chk("R5 r9 untouched", dataOut0, 32'd0);
    // R6: jump outputs zero-extended, data holds
    step({2'b11, 32'hFFFF_FFFF, 32'hABCD_1234}, "R6 jump");
    chk("R6 zext", jumpOut1, 32'h03FF_FFFF);
    // R7 R12: idle bundle with arbitrary fields changes nothing
    step({2'b00, iIns(6'd0, 0, 4, 16'd1), iIns(6'd0, 0, 4, 16'd2)}, "R7 idle");
    step({2'b01, rIns(6'd0, 4, 0, 0), rIns(6'd0, 4, 0, 0)}, "R7 r4 untouched");
    chk("R7 r4 zero", dataOut0, 32'd0);

    // Random mix across all selectors (R1-style layout) with codes 0..7
    for (int n = 0; n < 600; n++) begin
      logic [65:0] b;
      b[65:64] = 2'($urandom_range(0, 3));
      for (int l = 0; l < 2; l++) begin
        b[l*32 +: 32] = $urandom();
        b[l*32 + 26 +: 6] = 6'($urandom_range(0, 7));
      end
      step(b, "R12 random");
    end

    // R11: reset mid-run clears registers
    doReset();
    step({2'b01, rIns(6'd3, 20, 6, 0), rIns(6'd3, 3, 7, 0)}, "R11 regs after reset");
    chk("R11 r3|r7 zero", dataOut0, 32'd0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule